// File: doc/BRIEF.md
# Banked Extended-Memory Address Controller

This block steers each memory cycle of an 8-bit computer either to its main dynamic RAM or to an expansion RAM. The expansion RAM is seen through a fixed 16 KB window at 0x4000–0x7FFF. An 8-bit control port, written by the processor, holds two things. It holds a two-bit bank number that picks one of four 16 KB expansion banks. It also holds two active-low enables, one for the CPU and one for the video DMA engine.

A bus-ownership input tells the block which master drives the current cycle, and so which enable applies. When the cycle falls in the window and that master's enable is active, the block asserts the expansion-RAM enable and drops the main-RAM enable. It also puts the bank number on the bank-select lines, and the bank number takes the place of the two top address bits during the column phase of the multiplexed DRAM address. The control port reads back exactly what was last written. It resets to all ones, which disables extended mode for both masters.

Top module: `xmem_bank_ctrl`

## Requirements
- R1: Reset, which is asynchronous and active low, loads the control port with 0xFF, and `port_rdata` reads 0xFF.
- R2: A write (`port_wr` high at a rising clock edge) stores `port_wdata` in full. It governs routing from the next cycle on, and `port_rdata` returns the written byte unchanged.
- R3: When `cpu_owns` is high, control-port bit 4 is the enable for the cycle, and 0 means extended mode is on.
- R4: When `cpu_owns` is low, the video DMA engine owns the cycle and control-port bit 5 is the enable, where 0 means extended mode is on.
- R5: Only addresses with addr[15:14] = 01 (0x4000–0x7FFF) can go to extended memory. Every other address always goes to main memory.
- R6: `ext_ram_en` and `main_ram_en` are always complementary. `ext_ram_en` is high exactly when the address is in the window and the owning master's enable bit is 0.
- R7: When `col_phase` is low (row phase), `ma` equals addr[7:0].
- R8: When `col_phase` is high (column phase), `ma` equals addr[15:8]. On an extended cycle, ma[7] is replaced by control-port bit 3 and ma[6] by control-port bit 2.
- R9: `bank_sel` equals control-port bits {3,2} on an extended cycle and 00 otherwise.
- R10: Control-port bits 0, 1, 6 and 7 have no effect on any output other than `port_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_wr | input | 1 | Control-port write strobe |
| port_wdata | input | 8 | Control-port write data |
| port_rdata | output | 8 | Current control-port value |
| cpu_owns | input | 1 | High: CPU owns cycle; low: video DMA owns cycle |
| col_phase | input | 1 | Low: row address phase; high: column phase |
| addr | input | 16 | Address of the current cycle |
| ma | output | 8 | Multiplexed DRAM address |
| bank_sel | output | 2 | Extended bank number, 00 when not extended |
| ext_ram_en | output | 1 | Expansion RAM enable |
| main_ram_en | output | 1 | Main RAM enable |

## Verification
The bench sweeps both owners against all four enable-bit combinations and all four banks. It uses window edges (0x4000, 0x7FFF) and the neighbours just outside them (0x3FFF, 0x8000). A design that swapped the two enable bits would hand DMA cycles to the CPU's setting. A design with an off-by-one window decode would remap 0x3FFF or 0x8000. A design that swapped the bank bit order would send column addresses to the wrong bank. Further tests toggle the unrelated control bits to catch any leak into routing, and check that a write lands one cycle later and reads back whole.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
    localparam int PORT_W = 8;

    typedef struct packed {
        logic [PORT_W-1:0] port;
    } xm_state_t;
endpackage

// File: rtl/xm_port_reg.sv
module xm_port_reg
    import xmem_pkg::*;
#(
    parameter logic [PORT_W-1:0] RST_VAL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] port_q
);
    xm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.port = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.port <= RST_VAL;
        else        st_q      <= st_d;
    end

    assign port_q = st_q.port;
endmodule

// File: rtl/xm_window_dec.sv
module xm_window_dec
    import xmem_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int BANK_W   = 2,
    parameter int BANK_LSB = 2,
    parameter int CPU_BIT  = 4,
    parameter int DMA_BIT  = 5
) (
    input  logic [PORT_W-1:0] port,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cpu_owns,
    output logic              ext_sel,
    output logic [BANK_W-1:0] bank
);
    logic in_win;
    logic en_n;

    always_comb begin
        in_win  = (addr[ADDR_W-1 -: 2] == 2'b01);
        en_n    = cpu_owns ? port[CPU_BIT] : port[DMA_BIT];
        ext_sel = in_win & ~en_n;
        bank    = port[BANK_LSB +: BANK_W];
    end
endmodule

// File: rtl/xm_addr_mux.sv
module xm_addr_mux #(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 2,
    localparam int MA_W  = ADDR_W / 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              col_phase,
    input  logic              ext_sel,
    input  logic [BANK_W-1:0] bank,
    output logic [MA_W-1:0]   ma
);
    logic [MA_W-1:0] col;

    always_comb begin
        col = addr[ADDR_W-1:MA_W];
        if (ext_sel) col[MA_W-1 -: BANK_W] = bank;
        ma = col_phase ? col : addr[MA_W-1:0];
    end
endmodule

// File: rtl/xmem_bank_ctrl.sv
module xmem_bank_ctrl
    import xmem_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int BANK_W   = 2,
    parameter int BANK_LSB = 2,
    parameter int CPU_BIT  = 4,
    parameter int DMA_BIT  = 5,
    localparam int MA_W    = ADDR_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_wr,
    input  logic [PORT_W-1:0] port_wdata,
    output logic [PORT_W-1:0] port_rdata,
    input  logic              cpu_owns,
    input  logic              col_phase,
    input  logic [ADDR_W-1:0] addr,
    output logic [MA_W-1:0]   ma,
    output logic [BANK_W-1:0] bank_sel,
    output logic              ext_ram_en,
    output logic              main_ram_en
);
    logic [PORT_W-1:0] port_q;
    logic              ext_sel;
    logic [BANK_W-1:0] bank;

    xm_port_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (port_wr),
        .wr_data (port_wdata),
        .port_q  (port_q)
    );

    xm_window_dec #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BANK_LSB(BANK_LSB),
        .CPU_BIT(CPU_BIT), .DMA_BIT(DMA_BIT)
    ) u_dec (
        .port     (port_q),
        .addr     (addr),
        .cpu_owns (cpu_owns),
        .ext_sel  (ext_sel),
        .bank     (bank)
    );

    xm_addr_mux #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_mux (
        .addr      (addr),
        .col_phase (col_phase),
        .ext_sel   (ext_sel),
        .bank      (bank),
        .ma        (ma)
    );

    assign port_rdata  = port_q;
    assign ext_ram_en  = ext_sel;
    assign main_ram_en = ~ext_sel;
    assign bank_sel    = ext_sel ? bank : '0;
endmodule

// File: rtl/xmem_bank_ctrl_chk.sv
module xmem_bank_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        port_wr,
    input logic [7:0]  port_wdata,
    input logic [7:0]  port_rdata,
    input logic        cpu_owns,
    input logic        col_phase,
    input logic [15:0] addr,
    input logic [7:0]  ma,
    input logic [1:0]  bank_sel,
    input logic        ext_ram_en,
    input logic        main_ram_en
);
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> port_rdata == $past(port_wdata)); // R2
    AST_CPU_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_owns && port_rdata[4]) |-> !ext_ram_en); // R3
    AST_DMA_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_owns && port_rdata[5]) |-> !ext_ram_en); // R4
    AST_OUT_OF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:14] != 2'b01) |-> main_ram_en); // R5
    AST_ENABLES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ram_en != main_ram_en); // R6
    AST_ROW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !col_phase |-> ma == addr[7:0]); // R7
    AST_COL_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (col_phase && main_ram_en) |-> ma == addr[15:8]); // R8
    AST_BANK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        main_ram_en |-> bank_sel == 2'b00); // R9
endmodule

bind xmem_bank_ctrl xmem_bank_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_wdata(port_wdata),
    .port_rdata(port_rdata), .cpu_owns(cpu_owns), .col_phase(col_phase),
    .addr(addr), .ma(ma), .bank_sel(bank_sel), .ext_ram_en(ext_ram_en),
    .main_ram_en(main_ram_en)
);

// File: tb/xmem_bank_ctrl_tb_top.sv
module xmem_bank_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        port_wr = 0;
    logic [7:0]  port_wdata = '0;
    logic [7:0]  port_rdata;
    logic        cpu_owns = 1;
    logic        col_phase = 0;
    logic [15:0] addr = '0;
    logic [7:0]  ma;
    logic [1:0]  bank_sel;
    logic        ext_ram_en;
    logic        main_ram_en;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xmem_bank_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_wdata(port_wdata),
        .port_rdata(port_rdata), .cpu_owns(cpu_owns), .col_phase(col_phase),
        .addr(addr), .ma(ma), .bank_sel(bank_sel), .ext_ram_en(ext_ram_en),
        .main_ram_en(main_ram_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_port(input logic [7:0] v);
        @(negedge clk);
        port_wr = 1; port_wdata = v;
        @(negedge clk);
        port_wr = 0;
    endtask

    function automatic bit ref_ext(input logic [7:0] p, input bit cpu, input logic [15:0] a);
        return (a[15:14] == 2'b01) && !(cpu ? p[4] : p[5]);
    endfunction

    task automatic check_cycle(input logic [7:0] p, input bit cpu, input logic [15:0] a);
        bit e;
        logic [7:0] col;
        e = ref_ext(p, cpu, a);
        col = e ? {p[3:2], a[13:8]} : a[15:8];
        cpu_owns = cpu; addr = a; col_phase = 0;
        #1;
        chk(ext_ram_en == e, cpu ? "R3/R6 ext" : "R4/R6 ext", ext_ram_en, e);
        chk(main_ram_en == !e, "R5/R6 main", main_ram_en, !e);
        chk(bank_sel == (e ? p[3:2] : 2'b00), "R9 bank_sel", bank_sel, e ? p[3:2] : 0);
        chk(ma == a[7:0], "R7 row", ma, a[7:0]);
        col_phase = 1;
        #1;
        chk(ma == col, "R8 col", ma, col);
        col_phase = 0;
    endtask

    task automatic t_reset;
        rst_n = 0;
        #(CLK_PERIOD*2);
        chk(port_rdata == 8'hFF, "R1 reset value", port_rdata, 8'hFF);
        @(negedge clk); rst_n = 1;
        check_cycle(8'hFF, 1, 16'h4000);
        check_cycle(8'hFF, 0, 16'h4000);
    endtask

    task automatic t_write_timing;
        @(negedge clk);
        cpu_owns = 1; addr = 16'h4123;
        port_wr = 1; port_wdata = 8'hEF;
        #1;
        chk(ext_ram_en == 0, "R2 not before edge", ext_ram_en, 0);
        @(negedge clk);
        port_wr = 0;
        #1;
        chk(ext_ram_en == 1, "R2 after edge", ext_ram_en, 1);
        foreach (port_wdata[i]) begin
            write_port(8'h01 << i);
            chk(port_rdata == (8'h01 << i), "R2 readback", port_rdata, 8'h01 << i);
        end
        write_port(8'hA5);
        chk(port_rdata == 8'hA5, "R2 readback", port_rdata, 8'hA5);
    endtask

    task automatic t_sweep;
        logic [15:0] addrs[7] = '{16'h4000, 16'h7FFF, 16'h5A81, 16'h3FFF,
                                  16'h8000, 16'hC3C3, 16'h0000};
        for (int en = 0; en < 4; en++) begin
            for (int bk = 0; bk < 4; bk++) begin
                logic [7:0] p;
                p = 8'hC3;
                p[5:4] = en[1:0];
                p[3:2] = bk[1:0];
                write_port(p);
                for (int m = 0; m < 2; m++)
                    foreach (addrs[k]) check_cycle(p, m[0], addrs[k]);
            end
        end
    endtask

    task automatic t_ignored_bits;
        for (int v = 0; v < 16; v++) begin
            logic [7:0] p;
            p = {v[3], v[2], 2'b00, 2'b10, v[1], v[0]};
            write_port(p);
            cpu_owns = 1; addr = 16'h6B00; col_phase = 1;
            #1;
            chk(ext_ram_en == 1 && main_ram_en == 0, "R10 routing", ext_ram_en, 1);
            chk(ma == 8'hAB && bank_sel == 2'b10, "R10 address", ma, 8'hAB);
            cpu_owns = 0;
            #1;
            chk(ext_ram_en == 1 && bank_sel == 2'b10, "R10 dma routing", ext_ram_en, 1);
            col_phase = 0;
        end
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_write_timing();
                t_sweep();
                t_ignored_bits();
            end
            begin
                #(CLK_PERIOD*100000);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule